// File: doc/BRIEF.md
# Multi-channel pulse width and period capture unit

This block timestamps edges on up to four digital inputs against one shared free-running counter and turns those timestamps into width and period measurements. A prescaler divides the system clock so the counter advances once every `prescale + 1` clocks. Each input passes through a two-flop synchronizer before edge detection. Each channel runs in one of three modes:

- **Edge mode** measures the time between successive edges of one polarity.
- **Pulse mode** measures how long the input stays at its active level.
- **Both mode** reports the width of a pulse and its full period at the start of the next pulse.

In pulse and both modes, a channel toggles between an idle state and an active state on every capture. The edge polarity it watches flips with each toggle, so one timestamp path yields both kinds of measurement. All differences are taken modulo the counter width, so a single counter wrap between edges needs no special handling. Each result is presented as a one-cycle strobe with width and period words. A result also sets a pending flag when that channel's interrupt enable is on. A priority output names the lowest-numbered pending channel.

Top module: `pcap_unit`

## Requirements
- R1: Mode code 00 selects edge mode. Code 11 behaves the same way. In edge mode every active edge produces a report with width 0 and period equal to the counter ticks since the previous active edge.
- R2: Mode code 01 selects pulse mode. The edge that starts a pulse produces no report. The edge that ends the pulse reports width equal to the ticks spent at the active level, and period 0.
- R3: Mode code 10 selects both mode. Every edge that starts a pulse reports the previous pulse's width and the ticks from the previous pulse start to this one. The first such report after a start has width 0 and a period equal to the new timestamp.
- R4: With `ch_act_low` set, the active level is low, so falling edges take the role that rising edges take with it clear.
- R5: A start pulse clears the counter, both stored timestamps and the state of every channel. A timestamp is the counter value plus one. With prescale 0, an input that rises in the cycle right after start reports period 3 in edge mode, three clocks after it changes.
- R6: The counter advances once every `prescale + 1` clocks while running, so measured values are clock counts divided by `prescale + 1`.
- R7: Differences are modulo 2^CW. An edge-mode period of 70000 clocks at prescale 0 with CW = 16 reports 4464.
- R8: A report sets its channel's pending bit only when that channel's `ch_ie` bit is set. A `pend_clr` bit clears its pending bit. A start clears all pending bits.
- R9: `irq` is high while any bit is pending, and `irq_ch` gives the lowest-numbered pending channel.
- R10: Edges that reach several channels in the same cycle are each reported, in the same cycle, with none lost.
- R11: After a stop pulse the counter holds and edges produce no reports until the next start.
- R12: After reset, no report strobe, pending bit or `irq` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: clear counter, timestamps, states, pending bits; begin counting |
| stop | input | 1 | Pulse: halt counting and capturing |
| prescale | input | PW | Counter advances every prescale+1 clocks |
| ch_mode | input | 2*NCH | Two-bit mode per channel (00 edge, 01 pulse, 10 both) |
| ch_act_low | input | NCH | Active level per channel: 1 low, 0 high |
| ch_ie | input | NCH | Interrupt enable per channel |
| pin | input | NCH | Asynchronous capture inputs |
| pend_clr | input | NCH | Clear pending bit per channel |
| cap_valid | output | NCH | One-cycle report strobe per channel |
| cap_width | output | NCH*CW | Reported width per channel |
| cap_period | output | NCH*CW | Reported period per channel |
| pend | output | NCH | Pending flags |
| irq | output | 1 | Any pending flag set |
| irq_ch | output | CHW | Lowest pending channel index |

## Verification
The hardest condition to create from the ports is a counter wrap between two edges. The bench holds a channel's input for more than 2^16 clocks at prescale 0 and checks that the modular period comes out right. Edges landing in the same cycle on several channels are also hard to produce. The bench drives three inputs at one falling clock edge, with one of those channels masked. It then checks that all three strobes arrive in one cycle, and that the pending bits and the priority index step correctly as bits are cleared.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_BOTH  = 2'b10,
        MODE_ALT   = 2'b11
    } cap_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } ch_state_e;

    typedef struct packed {
        cap_mode_e mode;
        logic      act_low;
    } ch_cfg_t;

    function automatic logic is_edge_mode(cap_mode_e m);
        return !(m == MODE_PULSE || m == MODE_BOTH);
    endfunction

endpackage

// File: rtl/pcap_timebase.sv
module pcap_timebase #(
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic [PW-1:0] prescale,
    output logic          run,
    output logic [CW-1:0] count
);
    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            count <= '0;
            run   <= 1'b0;
        end else if (start) begin
            div_q <= '0;
            count <= '0;
            run   <= 1'b1;
        end else if (stop) begin
            run <= 1'b0;
        end else if (run) begin
            if (div_q == prescale) begin
                div_q <= '0;
                count <= count + CW'(1);
            end else begin
                div_q <= div_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/pcap_channel.sv
module pcap_channel
    import pcap_pkg::*;
#(
    parameter int CW   = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          run,
    input  ch_cfg_t       cfg,
    input  logic          pin,
    input  logic [CW-1:0] count,
    output logic          rpt_valid,
    output logic [CW-1:0] rpt_width,
    output logic [CW-1:0] rpt_period
);
    logic [SYNC:0] sh;
    logic          lvl_now, lvl_old, rise, fall;
    logic          edge_md, want_rise, hit;
    ch_state_e     st;
    logic [CW-1:0] t_act, t_idl, stamp;

    // synchronizer chain plus one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC-1:0], pin};
    end

    always_comb begin
        lvl_now   = sh[SYNC-1];
        lvl_old   = sh[SYNC];
        rise      = lvl_now & ~lvl_old;
        fall      = ~lvl_now & lvl_old;
        edge_md   = is_edge_mode(cfg.mode);
        want_rise = edge_md ? !cfg.act_low : ((st == ST_IDLE) ^ cfg.act_low);
        hit       = run && (want_rise ? rise : fall);
        stamp     = count + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            st         <= ST_IDLE;
            t_act      <= '0;
            t_idl      <= '0;
            rpt_valid  <= 1'b0;
            rpt_width  <= '0;
            rpt_period <= '0;
        end else begin
            rpt_valid <= 1'b0;
            if (hit) begin
                if (edge_md) begin
                    rpt_valid  <= 1'b1;
                    rpt_width  <= '0;
                    rpt_period <= stamp - t_idl;
                    t_idl      <= stamp;
                end else if (st == ST_IDLE) begin
                    st    <= ST_ACTIVE;
                    t_act <= stamp;
                    if (cfg.mode == MODE_BOTH) begin
                        rpt_valid  <= 1'b1;
                        rpt_width  <= t_idl - t_act;
                        rpt_period <= stamp - t_act;
                    end
                end else begin
                    st    <= ST_IDLE;
                    t_idl <= stamp;
                    if (cfg.mode == MODE_PULSE) begin
                        rpt_valid  <= 1'b1;
                        rpt_width  <= stamp - t_act;
                        rpt_period <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pcap_pending.sv
module pcap_pending #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [NCH-1:0] rpt,
    input  logic [NCH-1:0] ie,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] pend,
    output logic           irq,
    output logic [CHW-1:0] irq_ch
);
    always_ff @(posedge clk) begin
        if (rst || start) pend <= '0;
        else              pend <= (pend & ~clr) | (rpt & ie);
    end

    always_comb begin
        irq    = |pend;
        irq_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) irq_ch = CHW'(i);
        end
    end
endmodule

// File: rtl/pcap_unit.sv
module pcap_unit
    import pcap_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int PW  = 16,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [PW-1:0]     prescale,
    input  logic [2*NCH-1:0]  ch_mode,
    input  logic [NCH-1:0]    ch_act_low,
    input  logic [NCH-1:0]    ch_ie,
    input  logic [NCH-1:0]    pin,
    input  logic [NCH-1:0]    pend_clr,
    output logic [NCH-1:0]    cap_valid,
    output logic [NCH*CW-1:0] cap_width,
    output logic [NCH*CW-1:0] cap_period,
    output logic [NCH-1:0]    pend,
    output logic              irq,
    output logic [CHW-1:0]    irq_ch
);
    logic          run;
    logic [CW-1:0] count;

    pcap_timebase #(.CW(CW), .PW(PW)) u_tb (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .prescale(prescale), .run(run), .count(count)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_cfg_t cfg;
        assign cfg.mode    = cap_mode_e'(ch_mode[2*g +: 2]);
        assign cfg.act_low = ch_act_low[g];

        pcap_channel #(.CW(CW), .SYNC(2)) u_ch (
            .clk(clk), .rst(rst), .start(start), .run(run),
            .cfg(cfg), .pin(pin[g]), .count(count),
            .rpt_valid(cap_valid[g]),
            .rpt_width(cap_width[g*CW +: CW]),
            .rpt_period(cap_period[g*CW +: CW])
        );
    end

    pcap_pending #(.NCH(NCH), .CHW(CHW)) u_pend (
        .clk(clk), .rst(rst), .start(start), .rpt(cap_valid),
        .ie(ch_ie), .clr(pend_clr), .pend(pend), .irq(irq), .irq_ch(irq_ch)
    );
endmodule

// File: rtl/pcap_unit_chk.sv
module pcap_unit_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int CHW = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2*NCH-1:0]  ch_mode,
    input logic [NCH-1:0]    ch_ie,
    input logic [NCH-1:0]    cap_valid,
    input logic [NCH*CW-1:0] cap_width,
    input logic [NCH*CW-1:0] cap_period,
    input logic [NCH-1:0]    pend,
    input logic              irq,
    input logic [CHW-1:0]    irq_ch
);
    logic [NCH-1:0] below;
    always_comb begin
        below = '0;
        for (int i = 0; i < NCH; i++) begin
            if (i < int'(irq_ch)) below[i] = 1'b1;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_a
        // R1: edge-mode reports carry zero width
        p_edge_width_zero_r1: assert property (@(posedge clk) disable iff (rst)
            (cap_valid[g] && ($past(ch_mode[2*g +: 2]) inside {2'b00, 2'b11}))
            |-> (cap_width[g*CW +: CW] == '0));
        // R2: pulse-mode reports carry zero period
        p_pulse_period_zero_r2: assert property (@(posedge clk) disable iff (rst)
            (cap_valid[g] && $past(ch_mode[2*g +: 2]) == 2'b01)
            |-> (cap_period[g*CW +: CW] == '0));
        // R8: pending only rises for an enabled channel
        p_pend_needs_ie_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(pend[g]) |-> $past(ch_ie[g]));
    end

    // R8: start leaves nothing pending
    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $past(start) |-> (pend == '0));
    // R9: priority index names the lowest pending channel
    p_irq_lowest_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend[irq_ch] && ((pend & below) == '0)));
endmodule

bind pcap_unit pcap_unit_chk #(.NCH(NCH), .CW(CW), .CHW(CHW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .ch_mode(ch_mode), .ch_ie(ch_ie),
    .cap_valid(cap_valid), .cap_width(cap_width), .cap_period(cap_period),
    .pend(pend), .irq(irq), .irq_ch(irq_ch)
);

// File: tb/pcap_unit_test.sv
module pcap_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int PW  = 16;
    localparam int CHW = 2;

    typedef struct packed {
        logic [1:0]  mode;
        logic        low;
        logic [7:0]  pre;
        logic [15:0] act;
        logic [15:0] idl;
        logic [15:0] ew;
        logic [15:0] ep;
        logic [7:0]  en;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VT [NV] = '{
        '{2'd0, 1'b0, 8'd0, 16'd5, 16'd7,  16'd0, 16'd12, 8'd3},
        '{2'd0, 1'b1, 8'd0, 16'd4, 16'd9,  16'd0, 16'd13, 8'd3},
        '{2'd1, 1'b0, 8'd0, 16'd6, 16'd10, 16'd6, 16'd0,  8'd3},
        '{2'd1, 1'b1, 8'd2, 16'd9, 16'd12, 16'd3, 16'd0,  8'd3},
        '{2'd2, 1'b0, 8'd0, 16'd3, 16'd8,  16'd3, 16'd11, 8'd3},
        '{2'd2, 1'b1, 8'd3, 16'd8, 16'd12, 16'd2, 16'd5,  8'd3}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0, stop = 1'b0;
    logic [PW-1:0]     prescale = '0;
    logic [2*NCH-1:0]  ch_mode = '0;
    logic [NCH-1:0]    ch_act_low = '0, ch_ie = '0, pin = '0, pend_clr = '0;
    logic [NCH-1:0]    cap_valid, pend;
    logic [NCH*CW-1:0] cap_width, cap_period;
    logic              irq;
    logic [CHW-1:0]    irq_ch;

    pcap_unit #(.NCH(NCH), .CW(CW), .PW(PW), .CHW(CHW)) uut (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .prescale(prescale),
        .ch_mode(ch_mode), .ch_act_low(ch_act_low), .ch_ie(ch_ie), .pin(pin),
        .pend_clr(pend_clr), .cap_valid(cap_valid), .cap_width(cap_width),
        .cap_period(cap_period), .pend(pend), .irq(irq), .irq_ch(irq_ch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int      total = 0, bad = 0;
    bit      done = 0;
    longint  cyc = 0;
    int      rep_cnt  [NCH];
    longint  last_w   [NCH];
    longint  last_p   [NCH];
    longint  last_cyc [NCH];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rst) begin
                rep_cnt[i] = 0; last_w[i] = 0; last_p[i] = 0; last_cyc[i] = 0;
            end else if (cap_valid[i]) begin
                rep_cnt[i]  = rep_cnt[i] + 1;
                last_w[i]   = longint'(cap_width[i*CW +: CW]);
                last_p[i]   = longint'(cap_period[i*CW +: CW]);
                last_cyc[i] = cyc;
            end
        end
    end

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_unit();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    function automatic string vtag(vec_t v);
        string s;
        s = (v.mode == 2'd0) ? "R1" : (v.mode == 2'd1) ? "R2" : "R3";
        if (v.low) s = {s, " R4"};
        if (v.pre != 0) s = {s, " R6"};
        return s;
    endfunction

    initial begin
        int base;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R12: quiet after reset
        check("R12 valid", longint'(cap_valid), 0);
        check("R12 pend", longint'(pend), 0);
        check("R12 irq", longint'(irq), 0);

        ch_ie = '1;
        foreach (VT[k]) begin
            ch_mode          = '0;
            ch_mode[1:0]     = VT[k].mode;
            ch_act_low       = '0;
            ch_act_low[0]    = VT[k].low;
            prescale         = PW'(VT[k].pre);
            pin[0]           = VT[k].low;
            wait_n(6);
            start_unit();
            base = rep_cnt[0];
            for (int p = 0; p < 3; p++) begin
                pin[0] = ~VT[k].low;
                wait_n(int'(VT[k].act));
                pin[0] = VT[k].low;
                wait_n(int'(VT[k].idl));
            end
            wait_n(6);
            check({vtag(VT[k]), " count"}, rep_cnt[0] - base, longint'(VT[k].en));
            check({vtag(VT[k]), " width"}, last_w[0], longint'(VT[k].ew));
            check({vtag(VT[k]), " period"}, last_p[0], longint'(VT[k].ep));
        end

        // R5: first edge after start, prescale 0
        ch_mode = '0; ch_act_low = '0; prescale = '0; pin = '0;
        wait_n(6);
        start_unit();
        pin[0] = 1'b1;
        wait_n(6);
        check("R5 first period", last_p[0], 3);

        // R11: stopped unit ignores edges
        pin[0] = 1'b0;
        wait_n(6);
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        base = rep_cnt[0];
        pin[0] = 1'b1;
        wait_n(8);
        check("R11 no report", rep_cnt[0] - base, 0);

        // R10 R8 R9: simultaneous edges on three channels, channel 1 masked
        pin = '0;
        ch_ie = 4'b0101;
        wait_n(6);
        start_unit();
        wait_n(3);
        pin[2:0] = 3'b111;
        wait_n(6);
        check("R10 ch0 seen", longint'(rep_cnt[0] > 0), 1);
        check("R10 same cycle 0/1", last_cyc[0], last_cyc[1]);
        check("R10 same cycle 0/2", last_cyc[0], last_cyc[2]);
        check("R8 masked pend", longint'(pend), 5);
        check("R9 irq", longint'(irq), 1);
        check("R9 lowest", longint'(irq_ch), 0);
        @(negedge clk) pend_clr = 4'b0001;
        @(negedge clk) pend_clr = 4'b0000;
        check("R8 clear ch0", longint'(pend), 4);
        check("R9 next lowest", longint'(irq_ch), 2);
        @(negedge clk) pend_clr = 4'b0100;
        @(negedge clk) pend_clr = 4'b0000;
        check("R9 irq low", longint'(irq), 0);

        // R7: counter wrap between edges
        pin = '0; ch_ie = '1;
        wait_n(6);
        start_unit();
        pin[0] = 1'b1;
        wait_n(100);
        pin[0] = 1'b0;
        wait_n(69900);
        pin[0] = 1'b1;
        wait_n(6);
        check("R7 wrapped period", last_p[0], 4464);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R12: got %0d expected %0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule